// File: doc/BRIEF.md
# Masked Vector AND-NOT Lane Unit

This block is the bitwise AND-NOT stage of a vector execution pipe. It treats a vector of up to sixteen 32-bit lanes (512 bits) as raw bits. Each result lane is the inverse of a first operand lane ANDed with the matching second operand lane. Lane values are never interpreted as floating-point numbers and no exception is produced.

Decode selects one of three forms.
- **Legacy two-operand form:** the old destination is the first operand and the upper lanes are preserved.
- **Unmasked three-operand form:** lanes beyond the selected vector length are cleared.
- **Masked three-operand form:** the unmasked behaviour, plus per-lane write masking that either merges or zeroes. A broadcast option replicates lane 0 of the second operand, but only for memory operands.

A strobe on `in_valid` captures one operation. The new destination appears one clock later with a one-cycle `out_valid` pulse.

Top module: `andn_lane_unit`

## Requirements
- R1: In the unmasked form (`form_sel`=1), each active 32-bit result lane equals `~src_a` lane AND `src_b` lane, bit for bit with no value interpretation. All-ones in `src_a` yields zero, and all-zeros yields the `src_b` lane.
- R2: `vlen_sel` gives the active lane count: 0 selects 4 lanes, 1 selects 8 lanes, 2 or 3 select 16 lanes. Lane i occupies bits [32i+31:32i].
- R3: In the legacy form (`form_sel`=0), the first operand is `dst_old` and only lanes 0..3 are computed. Lanes 4..15 keep their `dst_old` value whatever `vlen_sel` is.
- R4: In the unmasked and masked forms, every lane at or above the active lane count is zero.
- R5: In the masked form (`form_sel`=2), an active lane whose `lane_mask` bit is 1 receives the computed value.
- R6: In the masked form, an active lane whose `lane_mask` bit is 0 becomes zero when `zero_en`=1, and keeps its `dst_old` value when `zero_en`=0.
- R7: In the masked form with `bcast_en`=1 and `mem_op`=1, lane 0 of `src_b` replaces every lane of `src_b`.
- R8: `bcast_en` with `mem_op`=0, or in any form other than masked, has no effect on the result.
- R9: The unmasked form ignores `lane_mask` and `zero_en`; all active lanes are written.
- R10: `form_sel`=3 behaves exactly as the unmasked form.
- R11: The result appears on `dst_new` one clock after an `in_valid` strobe, with `out_valid` high for exactly that cycle. `dst_new` holds its value while `in_valid` is low.
- R12: While reset is asserted, and after it is released until the first strobe, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source vector (inverted operand, three-operand forms) |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Previous destination contents |
| lane_mask | input | 16 | Per-lane write enable, masked form |
| vlen_sel | input | 2 | Vector length select |
| form_sel | input | 2 | 0 legacy, 1 unmasked, 2 masked, 3 unmasked |
| zero_en | input | 1 | Zero masked-off lanes instead of merging |
| bcast_en | input | 1 | Broadcast request |
| mem_op | input | 1 | Second source comes from memory |
| out_valid | output | 1 | Result valid pulse |
| dst_new | output | 512 | New destination vector |

## Verification
The result register is the only state, so a corrupted enable or valid flop shows on the ports within one cycle. It appears either as an `out_valid` pulse that is missing or repeated, or as a `dst_new` value that changes while no strobe is present. Faults in lane control show in the very next result. A wrong lane count or form decode appears as a nonzero or stale upper lane. A broken mask policy appears as a merged lane where zero was due, or the reverse. A broadcast fault appears as lanes 1 and up copying lane 0, or not copying it. The vector table pairs each form with lane patterns that make each of these faults change at least one bit.

// File: rtl/andn_pkg.sv
package andn_pkg;

  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_PLAIN  = 2'd1,
    FORM_MASKED = 2'd2,
    FORM_ALT    = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    VL_128 = 2'd0,
    VL_256 = 2'd1,
    VL_512 = 2'd2,
    VL_MAX = 2'd3
  } vlen_e;

endpackage

// File: rtl/andn_rst_sync.sv
module andn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/andn_lane_ctrl.sv
module andn_lane_ctrl
  import andn_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic [1:0]       vlen_sel,
  input  logic [1:0]       form_sel,
  input  logic             bcast_en,
  input  logic             mem_op,
  output logic [LANES-1:0] lane_active,
  output logic             sel_old_a,
  output logic             rep_b0,
  output logic             keep_upper,
  output logic             apply_mask
);

  localparam int CNT_W = $clog2(LANES + 1);
  localparam int L128  = 128 / LANE_W;
  localparam int L256  = 256 / LANE_W;
  localparam logic [CNT_W-1:0] N128 = CNT_W'(L128);
  localparam logic [CNT_W-1:0] N256 = CNT_W'(L256);
  localparam logic [CNT_W-1:0] NMAX = CNT_W'(LANES);

  logic [CNT_W-1:0] n_active;
  logic             is_legacy;
  logic             is_masked;

  always_comb begin
    is_legacy = (form_sel == FORM_LEGACY);
    is_masked = (form_sel == FORM_MASKED);
  end

  // Legacy form is clamped to the narrowest length
  always_comb begin
    if (is_legacy) begin
      n_active = N128;
    end else begin
      case (vlen_sel)
        VL_128:  n_active = N128;
        VL_256:  n_active = N256;
        default: n_active = NMAX;
      endcase
    end
  end

  for (genvar gi = 0; gi < LANES; gi++) begin : g_act
    localparam logic [CNT_W-1:0] IDX = CNT_W'(gi);
    assign lane_active[gi] = (IDX < n_active);
  end

  always_comb begin
    sel_old_a  = is_legacy;
    keep_upper = is_legacy;
    apply_mask = is_masked;
    rep_b0     = is_masked && bcast_en && mem_op;
  end

endmodule

// File: rtl/andn_lane_slice.sv
module andn_lane_slice #(
  parameter int LANE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] a_lane,
  input  logic [LANE_W-1:0] b_lane,
  input  logic [LANE_W-1:0] b_first,
  input  logic [LANE_W-1:0] old_lane,
  input  logic              active,
  input  logic              mask_bit,
  input  logic              sel_old_a,
  input  logic              rep_b0,
  input  logic              keep_upper,
  input  logic              apply_mask,
  input  logic              zero_en,
  output logic [LANE_W-1:0] res_lane
);

  logic [LANE_W-1:0] op_a;
  logic [LANE_W-1:0] op_b;
  logic [LANE_W-1:0] calc;

  always_comb begin
    op_a = sel_old_a ? old_lane : a_lane;
    op_b = rep_b0 ? b_first : b_lane;
    calc = ~op_a & op_b;
  end

  always_comb begin
    if (!active) begin
      res_lane = keep_upper ? old_lane : '0;
    end else if (apply_mask && !mask_bit) begin
      res_lane = zero_en ? '0 : old_lane;
    end else begin
      res_lane = calc;
    end
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (active && apply_mask && !mask_bit && zero_en) begin
        AST_MASKED_ZEROED: assert (res_lane == '0); // R6
      end
      if (!active && !keep_upper) begin
        AST_INACTIVE_CLEAR: assert (res_lane == '0); // R4
      end
    end
  end

endmodule

// File: rtl/andn_result_reg.sv
module andn_result_reg #(
  parameter int VEC_W = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [VEC_W-1:0] res_d,
  output logic             vld_q,
  output logic [VEC_W-1:0] dst_q
);

  logic             vld_d;
  logic [VEC_W-1:0] dst_d;

  always_comb begin
    vld_d = load_en;
    dst_d = load_en ? res_d : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dst_q <= '0;
    end else begin
      vld_q <= vld_d;
      dst_q <= dst_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> vld_q); // R11
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> !vld_q); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(dst_q)); // R11

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!vld_q); // R12
    end
  end

endmodule

// File: rtl/andn_lane_unit.sv
module andn_lane_unit
  import andn_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [LANES*LANE_W-1:0] src_a,
  input  logic [LANES*LANE_W-1:0] src_b,
  input  logic [LANES*LANE_W-1:0] dst_old,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [1:0]              vlen_sel,
  input  logic [1:0]              form_sel,
  input  logic                    zero_en,
  input  logic                    bcast_en,
  input  logic                    mem_op,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] dst_new
);

  localparam int VEC_W = LANES * LANE_W;
  localparam int L128  = 128 / LANE_W;
  localparam int LO_W  = L128 * LANE_W;

  logic             rst_n_s;
  logic [LANES-1:0] lane_active;
  logic             sel_old_a;
  logic             rep_b0;
  logic             keep_upper;
  logic             apply_mask;
  logic [VEC_W-1:0] res_vec;

  andn_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  andn_lane_ctrl #(
    .LANE_W (LANE_W),
    .LANES  (LANES)
  ) u_ctrl (
    .vlen_sel    (vlen_sel),
    .form_sel    (form_sel),
    .bcast_en    (bcast_en),
    .mem_op      (mem_op),
    .lane_active (lane_active),
    .sel_old_a   (sel_old_a),
    .rep_b0      (rep_b0),
    .keep_upper  (keep_upper),
    .apply_mask  (apply_mask)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    andn_lane_slice #(
      .LANE_W (LANE_W)
    ) u_slice (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .a_lane     (src_a[gl*LANE_W +: LANE_W]),
      .b_lane     (src_b[gl*LANE_W +: LANE_W]),
      .b_first    (src_b[LANE_W-1:0]),
      .old_lane   (dst_old[gl*LANE_W +: LANE_W]),
      .active     (lane_active[gl]),
      .mask_bit   (lane_mask[gl]),
      .sel_old_a  (sel_old_a),
      .rep_b0     (rep_b0),
      .keep_upper (keep_upper),
      .apply_mask (apply_mask),
      .zero_en    (zero_en),
      .res_lane   (res_vec[gl*LANE_W +: LANE_W])
    );
  end

  andn_result_reg #(
    .VEC_W (VEC_W)
  ) u_result (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_en (in_valid),
    .res_d   (res_vec),
    .vld_q   (out_valid),
    .dst_q   (dst_new)
  );

  AST_LEGACY_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && form_sel == FORM_LEGACY)
    |=> dst_new[VEC_W-1:LO_W] == $past(dst_old[VEC_W-1:LO_W])); // R3
  AST_UPPER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_valid && form_sel != FORM_LEGACY && vlen_sel == VL_128)
    |=> dst_new[VEC_W-1:LO_W] == '0); // R4

endmodule

// File: tb/andn_lane_unit_bench.sv
module andn_lane_unit_bench;

  localparam int LANE_W = 32;
  localparam int LANES  = 16;
  localparam int VEC_W  = LANE_W * LANES;

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  form;
    logic [1:0]  vl;
    logic [15:0] mask;
    logic        z;
    logic        b;
    logic        m;
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{4'd1,  2'd1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h1234_5678}, // R1 R4
    '{4'd2,  2'd1, 2'd1, 16'h0000, 1'b0, 1'b0, 1'b0, 32'hCAFE_0001}, // R2 8 lanes
    '{4'd2,  2'd1, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h0BAD_F00D}, // R2 16 lanes
    '{4'd2,  2'd1, 2'd3, 16'h0000, 1'b0, 1'b0, 1'b0, 32'h7777_1111}, // R2 code 3
    '{4'd3,  2'd0, 2'd0, 16'hFFFF, 1'b0, 1'b0, 1'b0, 32'h5A5A_0F0F}, // R3
    '{4'd3,  2'd0, 2'd2, 16'h0000, 1'b1, 1'b1, 1'b1, 32'h3C3C_9999}, // R3 clamp
    '{4'd6,  2'd2, 2'd2, 16'hA5A5, 1'b0, 1'b0, 1'b0, 32'h1357_9BDF}, // R6 merge
    '{4'd6,  2'd2, 2'd2, 16'hA5A5, 1'b1, 1'b0, 1'b0, 32'h2468_ACE0}, // R6 zero
    '{4'd5,  2'd2, 2'd1, 16'hFFFF, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R5 R4
    '{4'd7,  2'd2, 2'd2, 16'h0F0F, 1'b1, 1'b1, 1'b1, 32'hFEED_5EED}, // R7
    '{4'd8,  2'd2, 2'd2, 16'hF0F0, 1'b0, 1'b1, 1'b0, 32'h0101_0202}, // R8
    '{4'd9,  2'd1, 2'd2, 16'h0000, 1'b1, 1'b1, 1'b1, 32'hABCD_EF01}, // R9
    '{4'd10, 2'd3, 2'd1, 16'h0000, 1'b1, 1'b0, 1'b0, 32'h6666_4444}  // R10
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [VEC_W-1:0] src_a = '0;
  logic [VEC_W-1:0] src_b = '0;
  logic [VEC_W-1:0] dst_old = '0;
  logic [15:0]      lane_mask = '0;
  logic [1:0]       vlen_sel = '0;
  logic [1:0]       form_sel = '0;
  logic             zero_en = 1'b0;
  logic             bcast_en = 1'b0;
  logic             mem_op = 1'b0;
  logic             out_valid;
  logic [VEC_W-1:0] dst_new;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  andn_lane_unit #(.LANE_W(LANE_W), .LANES(LANES)) u_andn_lane_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .lane_mask(lane_mask), .vlen_sel(vlen_sel), .form_sel(form_sel),
    .zero_en(zero_en), .bcast_en(bcast_en), .mem_op(mem_op),
    .out_valid(out_valid), .dst_new(dst_new)
  );

  function automatic logic [VEC_W-1:0] mk(input logic [31:0] s, input int k);
    logic [VEC_W-1:0] v;
    for (int i = 0; i < LANES; i++) begin
      v[i*32 +: 32] = (s * 32'(i*7 + k*131 + 1)) ^ (32'h0101_0101 * 32'(i + k)) ^ 32'(k << 28);
    end
    return v;
  endfunction

  // Expected result from the requirements
  function automatic logic [VEC_W-1:0] model(
    input logic [1:0] f, input logic [1:0] vl, input logic [15:0] msk,
    input logic z, input logic b, input logic m,
    input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] bb, input logic [VEC_W-1:0] old);
    logic [VEC_W-1:0] r;
    int n;
    n = (f == 2'd0 || vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] ai, bi;
      ai = (f == 2'd0) ? old[i*32 +: 32] : a[i*32 +: 32];
      bi = (f == 2'd2 && b && m) ? bb[31:0] : bb[i*32 +: 32];
      if (i >= n) r[i*32 +: 32] = (f == 2'd0) ? old[i*32 +: 32] : 32'h0;
      else if (f == 2'd2 && !msk[i]) r[i*32 +: 32] = z ? 32'h0 : old[i*32 +: 32];
      else r[i*32 +: 32] = ~ai & bi;
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [VEC_W-1:0] act,
                           input logic [VEC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] f, input logic [1:0] vl, input logic [15:0] msk,
                       input logic z, input logic b, input logic m,
                       input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] bb,
                       input logic [VEC_W-1:0] old);
    @(negedge clk);
    form_sel = f; vlen_sel = vl; lane_mask = msk;
    zero_en = z; bcast_en = b; mem_op = m;
    src_a = a; src_b = bb; dst_old = old;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VEC_W-1:0] a, bb, old, exp, held;
    repeat (3) @(negedge clk);
    check_bit("R12 in reset", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R12 after release", out_valid, 1'b0);

    for (int t = 0; t < NV; t++) begin
      a   = mk(TBL[t].seed, 0);
      bb  = mk(TBL[t].seed, 1);
      old = mk(TBL[t].seed, 2);
      exp = model(TBL[t].form, TBL[t].vl, TBL[t].mask, TBL[t].z, TBL[t].b, TBL[t].m, a, bb, old);
      issue(TBL[t].form, TBL[t].vl, TBL[t].mask, TBL[t].z, TBL[t].b, TBL[t].m, a, bb, old);
      check_bit($sformatf("R11 valid vec %0d", t), out_valid, 1'b1);
      check_vec($sformatf("R%0d vec %0d", TBL[t].tag, t), dst_new, exp);
    end

    // R1 boundary operands: all-ones first source, then all-zeros
    bb = mk(32'h9999_0000, 1);
    issue(2'd1, 2'd2, 16'h0, 1'b0, 1'b0, 1'b0, {VEC_W{1'b1}}, bb, '0);
    check_vec("R1 ones", dst_new, '0);
    issue(2'd1, 2'd2, 16'h0, 1'b0, 1'b0, 1'b0, '0, bb, '0);
    check_vec("R1 zeros", dst_new, bb);

    // R11 hold: no strobe, inputs change, output stays
    held = dst_new;
    @(negedge clk);
    src_a = mk(32'h4242_4242, 0); src_b = mk(32'h4242_4242, 1);
    form_sel = 2'd2; lane_mask = 16'h0; zero_en = 1'b1;
    @(negedge clk);
    check_bit("R11 pulse ends", out_valid, 1'b0);
    check_vec("R11 hold", dst_new, held);

    // R12 reset mid-run clears valid
    issue(2'd1, 2'd0, 16'h0, 1'b0, 1'b0, 1'b0, '0, bb, '0);
    rst_n = 1'b0;
    #1;
    check_bit("R12 async clear", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R12 idle after reset", out_valid, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule